// File: doc/BRIEF.md
# Reduced-Shift Speculative Floating-Point Adder

This block adds or subtracts two single-precision IEEE-754 numbers (1 sign bit, 8 exponent bits, 23 fraction bits) through a datapath that has been cut down on the assumption that real workloads seldom need large shifts. The alignment shifter moves the smaller operand right by at most `ALIGN_MAX` places. The normalisation shifter moves the raw sum left by at most `NORM_MAX` places. No stage exchanges the operands, so operand A must be the one with the larger magnitude. Exponents are accepted only inside the window `EXP_LO`..`EXP_HI`. Both shifters are built as chains of multiplexer stages, one stage per power-of-two shift, and the chain is only as long as the limit requires.

Every operation is screened. When an operation needs something the reduced datapath does not provide, the result is marked with an error flag instead of being trusted. Surrounding logic, or a host, then repeats the operation on a unit with full capability. When the flag is clear, the result is the correctly rounded IEEE value (round to nearest, ties to even). Full compliance therefore survives at the system level.

The unit takes one operation per cycle. Each result, with its flag, appears two cycles after the operation is accepted.

Top module: `rsfa_adder`

## Requirements
- R1: When `out_err` is 0, `out_result` equals the IEEE-754 single-precision value of `in_a + in_b` (`in_sub`=0) or `in_a - in_b` (`in_sub`=1), rounded to nearest with ties to even. The result takes the sign of `in_a`.
- R2: `out_valid`, `out_result` and `out_err` belong to the operation accepted with `in_valid`=1 exactly two rising edges earlier. During reset and right after it, `out_valid` and `out_err` are 0.
- R3: If either operand has exponent field 0 (zero or denormal) or 255 (infinity or NaN), the error flag is set.
- R4: If either operand's biased exponent lies below `EXP_LO` or above `EXP_HI`, the error flag is set.
- R5: If the magnitude of A is smaller than that of B (comparing bits 30:0 as an unsigned number), the error flag is set. Equal magnitudes do not set the flag under this rule.
- R6: If the biased exponent of A exceeds that of B by more than `ALIGN_MAX`, the error flag is set. A difference of exactly `ALIGN_MAX` is computed normally.
- R7: If the exact sum needs a left normalisation shift of more than `NORM_MAX` places, the error flag is set. An exactly zero sum counts as needing an unbounded shift. A carry out of the leading bit, which needs a one-place right shift, is always handled.
- R8: If the exponent of the final rounded result lies outside `EXP_LO`..`EXP_HI`, the error flag is set. This includes an increment caused by a carry or by rounding.
- R9: The error flag is 0 whenever none of the conditions in R3 to R8 holds.
- R10: A new operation is accepted on every cycle that `in_valid` is 1, with no stall. Every accepted operation produces exactly one output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_a | input | 32 | Operand A, single precision, expected to have the larger magnitude |
| in_b | input | 32 | Operand B, single precision |
| in_sub | input | 1 | 1 selects A minus B, 0 selects A plus B |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Rounded result; meaningful only when `out_err` is 0 |
| out_err | output | 1 | Operation must be re-executed on a full-capability unit |

## Verification
The two functions that can fall in the same cycle are the one-place right renormalisation after a carry out and the exponent window test on the final result. The same applies to the rounding increment that may follow them. A carry at the top of the window must be flagged, while the same carry one exponent lower must still give an exact result. Directed operations with an all-ones fraction at `EXP_HI` and `EXP_HI`-1 provoke this. Random operands drawn around the window edges and the shift limits are judged against a bench model. The model computes the exact sum as a wide integer, derives the needed shifts and the rounded exponent from it, and predicts both the flag and the value.

// File: rtl/rsfa_pkg.sv
package rsfa_pkg;

    // Single-precision operand as seen by the reduced datapath
    typedef struct packed {
        logic        sign;
        logic [7:0]  expo;
        logic [22:0] frac;
    } fp32_t;

    // Significand width including the hidden one
    localparam int MANT_W = 24;

endpackage

// File: rtl/rsfa_screen.sv
// Operand screening: decides up front whether the reduced datapath can take
// the operation, and produces the alignment distance when it can.
module rsfa_screen
    import rsfa_pkg::*;
#(
    parameter int ALIGN_MAX = 7,
    parameter int EXP_LO    = 100,
    parameter int EXP_HI    = 160
) (
    input  fp32_t                          op_a,
    input  fp32_t                          op_b,
    input  logic                           sub,
    output logic                           flag,
    output logic                           eff_sub,
    output logic [$clog2(ALIGN_MAX+1)-1:0] shamt
);
    localparam int         AW    = $clog2(ALIGN_MAX + 1);
    localparam logic [7:0] LO8   = 8'(EXP_LO);
    localparam logic [7:0] HI8   = 8'(EXP_HI);
    localparam logic [8:0] AMAX9 = 9'(ALIGN_MAX);

    logic       special;
    logic       outside;
    logic       swap_need;
    logic       too_far;
    logic [8:0] diff;

    always_comb begin
        // zero, denormal, infinity, NaN on either side
        special   = (op_a.expo == 8'h00) || (op_a.expo == 8'hFF) ||
                    (op_b.expo == 8'h00) || (op_b.expo == 8'hFF);
        outside   = (op_a.expo < LO8) || (op_a.expo > HI8) ||
                    (op_b.expo < LO8) || (op_b.expo > HI8);
        // no exchange stage: A must not be the smaller magnitude
        swap_need = {op_a.expo, op_a.frac} < {op_b.expo, op_b.frac};
        diff      = {1'b0, op_a.expo} - {1'b0, op_b.expo};
        too_far   = !swap_need && (diff > AMAX9);
        flag      = special || outside || swap_need || too_far;
        eff_sub   = op_a.sign ^ op_b.sign ^ sub;
        shamt     = (swap_need || too_far) ? '0 : diff[AW-1:0];
    end

endmodule

// File: rtl/rsfa_shifter.sv
// Limited-range shifter built from multiplexer stages; stage k moves the
// word by 2**k places. Only the stages needed to reach MAXSH are generated.
module rsfa_shifter #(
    parameter int W     = 31,
    parameter int MAXSH = 7,
    parameter bit LEFT  = 1'b0
) (
    input  logic [W-1:0]                   din,
    input  logic [$clog2(MAXSH+1)-1:0]     amt,
    output logic [W-1:0]                   dout
);
    localparam int NS = $clog2(MAXSH + 1);

    logic [W-1:0] lvl [NS+1];

    assign lvl[0] = din;

    for (genvar k = 0; k < NS; k++) begin : g_stage
        if (LEFT) begin : g_left
            assign lvl[k+1] = amt[k] ? (lvl[k] << (2**k)) : lvl[k];
        end else begin : g_right
            assign lvl[k+1] = amt[k] ? (lvl[k] >> (2**k)) : lvl[k];
        end
    end

    assign dout = lvl[NS];

endmodule

// File: rtl/rsfa_lzc.sv
// Leading-zero counter that only looks at the top LIMIT+1 bits; anything
// deeper is reported as over the limit.
module rsfa_lzc #(
    parameter int W     = 31,
    parameter int LIMIT = 3
) (
    input  logic [W-1:0]                din,
    output logic [$clog2(LIMIT+1)-1:0]  cnt,
    output logic                        over
);
    localparam int CW = $clog2(LIMIT + 1);

    always_comb begin
        cnt  = '0;
        over = 1'b1;
        // scan from the deepest allowed bit upward; the last hit is the MSB
        for (int i = LIMIT; i >= 0; i--) begin
            if (din[W-1-i]) begin
                cnt  = CW'(i);
                over = 1'b0;
            end
        end
    end

endmodule

// File: rtl/rsfa_adder.sv
// Reduced-shift speculative single-precision adder, two register stages.
module rsfa_adder
    import rsfa_pkg::*;
#(
    parameter int ALIGN_MAX = 7,
    parameter int NORM_MAX  = 3,
    parameter int EXP_LO    = 100,
    parameter int EXP_HI    = 160
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    input  logic        in_sub,
    output logic        out_valid,
    output logic [31:0] out_result,
    output logic        out_err
);
    localparam int FW = MANT_W + ALIGN_MAX;      // exact aligned significand
    localparam int SW = FW + 1;                  // plus carry
    localparam int AW = $clog2(ALIGN_MAX + 1);
    localparam int NW = $clog2(NORM_MAX + 1);

    typedef struct packed {
        logic          valid;
        logic          err;
        logic          sign;
        logic [7:0]    expo;
        logic [SW-1:0] sum;
    } align_t;

    typedef struct packed {
        logic        valid;
        logic        err;
        logic [31:0] result;
    } norm_t;

    align_t s1_d, s1_q;
    norm_t  s2_d, s2_q;

    // ---------------- stage 1: screen, align, add ----------------
    fp32_t          a_w, b_w;
    logic           scr_flag;
    logic           eff_sub;
    logic [AW-1:0]  shamt;
    logic [FW-1:0]  mant_a, mant_b, mant_b_al;

    assign a_w = in_a;
    assign b_w = in_b;

    rsfa_screen #(
        .ALIGN_MAX(ALIGN_MAX),
        .EXP_LO   (EXP_LO),
        .EXP_HI   (EXP_HI)
    ) i_screen (
        .op_a   (a_w),
        .op_b   (b_w),
        .sub    (in_sub),
        .flag   (scr_flag),
        .eff_sub(eff_sub),
        .shamt  (shamt)
    );

    // ALIGN_MAX extra low bits keep the aligned operand exact
    assign mant_a = {1'b1, a_w.frac, {ALIGN_MAX{1'b0}}};
    assign mant_b = {1'b1, b_w.frac, {ALIGN_MAX{1'b0}}};

    rsfa_shifter #(
        .W    (FW),
        .MAXSH(ALIGN_MAX),
        .LEFT (1'b0)
    ) i_align (
        .din (mant_b),
        .amt (shamt),
        .dout(mant_b_al)
    );

    always_comb begin
        s1_d       = '0;
        s1_d.valid = in_valid;
        s1_d.err   = scr_flag;
        s1_d.sign  = a_w.sign;
        s1_d.expo  = a_w.expo;
        s1_d.sum   = eff_sub ? ({1'b0, mant_a} - {1'b0, mant_b_al})
                             : ({1'b0, mant_a} + {1'b0, mant_b_al});
    end

    // ---------------- stage 2: normalise, round, range ----------------
    logic [NW-1:0]  lz;
    logic           lz_over;
    logic [FW-1:0]  norm_w;
    logic           carry;
    logic [SW-1:0]  vec;
    logic [23:0]    mant;
    logic           guard, sticky, rnd_up;
    logic [24:0]    mant_r;
    logic [9:0]     exp_r;
    logic           win_bad;

    rsfa_lzc #(
        .W    (FW),
        .LIMIT(NORM_MAX)
    ) i_lzc (
        .din (s1_q.sum[FW-1:0]),
        .cnt (lz),
        .over(lz_over)
    );

    rsfa_shifter #(
        .W    (FW),
        .MAXSH(NORM_MAX),
        .LEFT (1'b1)
    ) i_norm (
        .din (s1_q.sum[FW-1:0]),
        .amt (lz),
        .dout(norm_w)
    );

    always_comb begin
        carry   = s1_q.sum[SW-1];
        vec     = carry ? s1_q.sum : {norm_w, 1'b0};
        mant    = vec[SW-1 -: 24];
        guard   = vec[SW-25];
        sticky  = |vec[SW-26:0];
        rnd_up  = guard & (sticky | mant[0]);
        mant_r  = {1'b0, mant} + 25'(rnd_up);
        exp_r   = {2'b00, s1_q.expo} + 10'(carry) + 10'(mant_r[24])
                  - (carry ? 10'd0 : 10'(lz));
        win_bad = ($signed(exp_r) < $signed(10'(EXP_LO))) ||
                  ($signed(exp_r) > $signed(10'(EXP_HI)));

        s2_d        = '0;
        s2_d.valid  = s1_q.valid;
        s2_d.err    = s1_q.err || (!carry && lz_over) || win_bad;
        s2_d.result = {s1_q.sign, exp_r[7:0],
                       mant_r[24] ? mant_r[23:1] : mant_r[22:0]};
    end

    // ---------------- registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid  = s2_q.valid;
    assign out_result = s2_q.result;
    assign out_err    = s2_q.err;

    // ---------------- assertions ----------------
    AST_ACCEPT_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_q.valid);                                           // R10

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        s1_q.valid |=> out_valid);                                          // R2

    AST_SPECIAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((in_a[30:23] == 8'h00) || (in_a[30:23] == 8'hFF) ||
                      (in_b[30:23] == 8'h00) || (in_b[30:23] == 8'hFF)))
        |=> s1_q.err);                                                      // R3

    AST_NORM_LEADING_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && !s2_d.err) |-> vec[SW-1]);                           // R7

    AST_EXP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |->
        ((out_result[30:23] >= 8'(EXP_LO)) && (out_result[30:23] <= 8'(EXP_HI)))); // R8

endmodule

// File: tb/test_rsfa_adder.sv
module test_rsfa_adder;

    localparam int AMAX = 7;
    localparam int NMAX = 3;
    localparam int LO   = 100;
    localparam int HI   = 160;
    localparam int QD   = 8192;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_a, in_b;
    logic        in_sub;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_err;

    always #5 clk = ~clk;   // 100 MHz

    rsfa_adder #(
        .ALIGN_MAX(AMAX),
        .NORM_MAX (NMAX),
        .EXP_LO   (LO),
        .EXP_HI   (HI)
    ) i_rsfa_adder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_sub    (in_sub),
        .out_valid (out_valid),
        .out_result(out_result),
        .out_err   (out_err)
    );

    int     checks = 0;
    int     errors = 0;
    bit     done   = 1'b0;
    longint cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        logic        err;
        logic [2:0]  cause;   // 0 none, 3..7 -> R3..R7, 1 -> R8
        logic [31:0] res;
    } pred_t;

    logic [31:0] q_res   [QD];
    logic        q_err   [QD];
    logic [2:0]  q_cause [QD];
    longint      q_cyc   [QD];
    int          wr = 0;
    int          rd = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd3:    return "R3";
            3'd4:    return "R4";
            3'd5:    return "R5";
            3'd6:    return "R6";
            3'd7:    return "R7";
            3'd1:    return "R8";
            default: return "R9";
        endcase
    endfunction

    // Behavioural model: exact integer sum, then IEEE rounding
    function automatic pred_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic sub);
        pred_t  r;
        int     ea, eb, d, p, e, sh;
        longint ma, mb, s, m, rem, half;
        logic   es;
        r  = '0;
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        if (ea == 0 || ea == 255 || eb == 0 || eb == 255) begin
            r.err = 1'b1; r.cause = 3'd3; return r;          // R3
        end
        if (ea < LO || ea > HI || eb < LO || eb > HI) begin
            r.err = 1'b1; r.cause = 3'd4; return r;          // R4
        end
        if (a[30:0] < b[30:0]) begin
            r.err = 1'b1; r.cause = 3'd5; return r;          // R5
        end
        d = ea - eb;
        if (d > AMAX) begin
            r.err = 1'b1; r.cause = 3'd6; return r;          // R6
        end
        ma = longint'({1'b1, a[22:0]});
        mb = longint'({1'b1, b[22:0]});
        es = a[31] ^ b[31] ^ sub;
        s  = es ? (ma <<< d) - mb : (ma <<< d) + mb;
        if (s == 0) begin
            r.err = 1'b1; r.cause = 3'd7; return r;          // R7
        end
        p = 0;
        for (int i = 0; i < 63; i++) if (s[i]) p = i;
        e = p + eb - 23;
        if (ea - e > NMAX) begin
            r.err = 1'b1; r.cause = 3'd7; return r;          // R7
        end
        if (p > 23) begin
            sh   = p - 23;
            m    = s >>> sh;
            rem  = s - (m <<< sh);
            half = longint'(1) <<< (sh - 1);
            if (rem > half || (rem == half && m[0])) m = m + 1;
        end else begin
            m = s <<< (23 - p);
        end
        if (m == (longint'(1) <<< 24)) begin
            m = m >>> 1;
            e = e + 1;
        end
        if (e < LO || e > HI) begin
            r.err = 1'b1; r.cause = 3'd1; return r;          // R8
        end
        r.res = {a[31], 8'(e), m[22:0]};
        return r;
    endfunction

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sub);
        pred_t pr;
        @(negedge clk);
        in_valid = 1'b1;
        in_a     = a;
        in_b     = b;
        in_sub   = sub;
        pr           = model(a, b, sub);
        q_res[wr]    = pr.res;
        q_err[wr]    = pr.err;
        q_cause[wr]  = pr.cause;
        q_cyc[wr]    = cyc;
        wr           = wr + 1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (rd >= wr) begin
                chk(1'b0, "R10 unexpected output", 64'(rd), 64'(wr));
            end else begin
                chk(cyc == q_cyc[rd] + 2, "R2 latency", 64'(cyc), 64'(q_cyc[rd] + 2));
                chk(out_err == q_err[rd], tag_of(q_cause[rd]), 64'(out_err), 64'(q_err[rd]));
                if (!q_err[rd] && !out_err)
                    chk(out_result == q_res[rd], "R1 result", 64'(out_result), 64'(q_res[rd]));
                rd = rd + 1;
            end
        end
    end

    function automatic logic [31:0] mk(input logic s, input int e, input logic [22:0] f);
        return {s, 8'(e), f};
    endfunction

    initial begin
        int unsigned seed_v;
        seed_v   = $urandom(32'd20240611);
        in_valid = 1'b0;
        in_a     = '0;
        in_b     = '0;
        in_sub   = 1'b0;
        rst_n    = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R2 reset valid", 64'(out_valid), 64'd0);
        chk(out_err == 1'b0, "R2 reset err", 64'(out_err), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 idle after reset", 64'(out_valid), 64'd0);

        // directed corners
        issue(32'h3FC00000, 32'h3FC00000, 1'b0);          // R1 1.5+1.5 carry out
        issue(32'h3FC00000, 32'h3FA00000, 1'b1);          // R1 1.5-1.25, shift 2
        issue(32'h3F800000, 32'h3F800000, 1'b1);          // R7 exact zero
        issue(32'h3F800000, 32'h3F700000, 1'b1);          // R7 shift 4
        issue(32'h00000000, 32'h3F800000, 1'b0);          // R3 zero
        issue(32'h7F800000, 32'h3F800000, 1'b0);          // R3 infinity
        issue(mk(0, 99, 0), mk(0, 99, 0), 1'b0);          // R4 below window
        issue(mk(0, 161, 0), mk(0, 150, 0), 1'b0);        // R4 above window
        issue(32'h3F800000, 32'h40000000, 1'b0);          // R5 A smaller
        issue(32'h3F800001, 32'h3F800001, 1'b0);          // R5 equal, not flagged
        issue(mk(0, 127, 23'h123456), mk(1, 127 - AMAX, 23'h654321), 1'b0);      // R6 at limit
        issue(mk(0, 127, 23'h123456), mk(0, 127 - AMAX - 1, 23'h654321), 1'b0);  // R6 over
        issue(mk(0, HI, 23'h7FFFFF), mk(0, HI - AMAX, 23'h7FFFFF), 1'b0);        // R8 carry at top
        issue(mk(0, HI - 1, 23'h7FFFFF), mk(0, HI - 1 - AMAX, 23'h7FFFFF), 1'b0);// R1 carry in range
        issue(mk(0, LO, 0), mk(0, LO - 1, 23'h400000), 1'b1);                    // R4 operand low
        issue(mk(0, LO + 1, 0), mk(0, LO, 23'h400000), 1'b1);                    // R8 result low
        issue(mk(1, 130, 23'h000001), mk(0, 129, 23'h7FFFFF), 1'b1);             // R1 signs mixed
        idle();
        idle();

        // constrained random stream, back to back with occasional gaps (R10)
        for (int n = 0; n < 3000; n++) begin
            int          ea, eb, r;
            logic [22:0] fa, fb;
            r  = int'($urandom % 16);
            ea = LO - 3 + int'($urandom % (HI - LO + 7));
            if (r == 0) ea = 0;
            if (r == 1) ea = 255;
            eb = ea - int'($urandom % (AMAX + 3));
            if ($urandom % 8 == 0) eb = ea + 1;
            if ($urandom % 4 == 0) eb = ea;
            if (eb < 0) eb = 0;
            if (eb > 255) eb = 255;
            fa = 23'($urandom);
            fb = ($urandom % 3 == 0) ? (fa ^ 23'($urandom % 64)) : 23'($urandom);
            issue(mk(1'($urandom), ea, fa), mk(1'($urandom), eb, fb), 1'($urandom));
            if ($urandom % 6 == 0) idle();
        end
        idle();
        repeat (6) @(negedge clk);
        chk(rd == wr, "R10 output count", 64'(rd), 64'(wr));
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", rd, wr);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule